// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Channel

This block takes stereo sample pairs from a register bus, holds them in a small FIFO and shifts them out on a serial data line in I2S framing. The bit timing is not generated here. The surrounding logic supplies a one-cycle bit strobe and a word-select level, both synchronous to the system clock. Word select low carries the left sample and high carries the right sample. The most significant bit leaves one bit strobe after each word-select change, and only as many bits as the programmed resolution are sent.

Software first writes the left sample and then the right sample. The right-sample write pushes the pair into the FIFO. Four enable bits gate the serialiser: global, transmit block, channel and clock. It runs only when all four are set. A programmable threshold drives a "FIFO low" status bit. A write into a full FIFO sets a sticky overrun bit, and a read of a dedicated address clears it. Both status bits reach one interrupt line through a mask.

The block has a flush command that drops every queued pair and leaves the configuration as it was. On underflow the line carries zeros and no state is disturbed, so the next pair written goes out in a later frame.

Top module: `i2s_tx_chan`

## Requirements
- R1: After reset, the following hold. `sd_out` is 0 and `irq_out` is 0. Reading address 4 (resolution) gives 2. Reading address 5 (threshold) gives 7. Reading address 6 (mask) gives 0x30. Reading address 7 (status) gives 0x10.
- R2: Serial data shifts only while all four enable registers have bit 0 set: address 0 (global), 1 (transmit block), 2 (channel) and 3 (clock). With any of them clear, `sd_out` stays 0 and no FIFO entry is consumed.
- R3: Address 4 holds a 3-bit resolution code. Code 2 sends 16 bits, code 4 sends 24 bits and code 5 sends 32 bits, taken from the low bits of each written sample. Any other code sends zeros.
- R4: Bits go out MSB first. The MSB appears on the bit strobe after the one at which a word-select change is sampled. Once the sample's bits are sent, `sd_out` is 0 until the next change.
- R5: Address 5 holds the low level minus one. Status bit 4 is set exactly when the FIFO occupancy is at most that value plus one.
- R6: The FIFO holds 16 pairs. A right-sample write (address 11) while the FIFO is full is dropped and sets status bit 5. Bit 5 stays set until address 8 is read. That read returns the flag in bit 0 and clears it.
- R7: Mask bit 4 masks the low-level interrupt and mask bit 5 masks the overrun interrupt. A set bit masks its source. `irq_out` is the OR of the unmasked status bits.
- R8: Writing 1 in bit 0 to address 9 empties the FIFO. Resolution, threshold, mask and enable registers are left unchanged.
- R9: When a left word starts with the FIFO empty, both words of that frame are zero and nothing is consumed. A pair written later is sent in a later frame.
- R10: Pairs leave in write order. The left sample is written at address 10 and the right sample at address 11. The left sample goes out while word select is low and the right sample while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| ws_in | input | 1 | Word select, sampled on `bit_tick` |
| sd_out | output | 1 | Serial data |
| irq_out | output | 1 | Interrupt, OR of unmasked status |

## Verification
The bench goes after six corner cases.
- Word alignment at each resolution. A design one strobe early or late would shift every word by one bit. A design that took the wrong bits of the sample would send the top bits instead of the low ones.
- The 32-bit case, where the last bit shares its strobe with the next word-select change. A wrong design would lose that LSB or corrupt the following MSB.
- The full FIFO. A design that overwrote the oldest entry, or miscounted its depth, would send a 17th pair or skip a queued one.
- The threshold boundary at exactly level and level plus one. An off-by-one would flip the low-level bit one entry early or late.
- Partial enables. A design that drained the FIFO while partly disabled would lose queued pairs.
- Underflow recovery. A design that moved its pointers on underflow would replay stale data or misalign left and right.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
// Package: register addresses and resolution decode for the serial audio
// transmit channel. Assumes a 4-bit register address space.
package i2s_tx_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_GLB = 4'd0;   // global enable
    localparam logic [ADDR_W-1:0] A_TXB = 4'd1;   // transmit block enable
    localparam logic [ADDR_W-1:0] A_CHN = 4'd2;   // channel enable
    localparam logic [ADDR_W-1:0] A_CLK = 4'd3;   // clock enable
    localparam logic [ADDR_W-1:0] A_RES = 4'd4;   // resolution code
    localparam logic [ADDR_W-1:0] A_THR = 4'd5;   // low level minus one
    localparam logic [ADDR_W-1:0] A_MSK = 4'd6;   // interrupt mask
    localparam logic [ADDR_W-1:0] A_STS = 4'd7;   // status
    localparam logic [ADDR_W-1:0] A_OVC = 4'd8;   // overrun clear on read
    localparam logic [ADDR_W-1:0] A_FLS = 4'd9;   // FIFO flush
    localparam logic [ADDR_W-1:0] A_LFT = 4'd10;  // left sample
    localparam logic [ADDR_W-1:0] A_RGT = 4'd11;  // right sample, pushes pair

    localparam logic [2:0] RES_RESET = 3'd2;

    // Number of serial bits for a resolution code; 0 for unsupported codes.
    function automatic int unsigned res_bits(input logic [2:0] code);
        case (code)
            3'd2:    return 16;
            3'd4:    return 24;
            3'd5:    return 32;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/i2s_tx_fifo.sv
`timescale 1ns/1ps
// Module: sample-pair FIFO with occupancy count and flush.
// Assumes DEPTH is a power of two. Pushes into a full FIFO and pops from an
// empty one are ignored; flush has priority over both.
module i2s_tx_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    input  logic             flush,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count)); // R6
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R8
endmodule

// File: rtl/i2s_tx_regs.sv
`timescale 1ns/1ps
// Module: register file, status, overrun flag and interrupt for the channel.
// Assumes reads return data one cycle after the read strobe. A left-sample
// write is held and paired with the next right-sample write.
module i2s_tx_regs
    import i2s_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int THR_W  = $clog2(DEPTH),
    parameter int CNT_W  = THR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [CNT_W-1:0]      fifo_count,
    input  logic                  fifo_full,
    output logic                  run,
    output logic [2:0]            res_code,
    output logic                  push,
    output logic [2*DATA_W-1:0]   push_pair,
    output logic                  flush,
    output logic                  irq
);
    localparam logic [THR_W-1:0] THR_RESET = THR_W'(DEPTH / 2 - 1);

    logic [3:0]        en_q;      // global, block, channel, clock
    logic [2:0]        res_q;
    logic [THR_W-1:0]  thr_q;
    logic [1:0]        msk_q;     // [0] low-level, [1] overrun
    logic              ovr_q;
    logic [DATA_W-1:0] left_q;
    logic              low_flag, ovr_clr;
    logic [DATA_W-1:0] rd_mux;

    assign run       = &en_q;
    assign res_code  = res_q;
    assign push      = bus_wr && (bus_addr == A_RGT);
    assign push_pair = {left_q, bus_wdata};
    assign flush     = bus_wr && (bus_addr == A_FLS) && bus_wdata[0];
    assign ovr_clr   = bus_rd && (bus_addr == A_OVC);
    assign low_flag  = ({1'b0, fifo_count} <= ((CNT_W+1)'(thr_q) + 1'b1));
    assign irq       = (low_flag && !msk_q[0]) || (ovr_q && !msk_q[1]);

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            res_q  <= RES_RESET;
            thr_q  <= THR_RESET;
            msk_q  <= 2'b11;
            left_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_GLB: en_q[0] <= bus_wdata[0];
                A_TXB: en_q[1] <= bus_wdata[0];
                A_CHN: en_q[2] <= bus_wdata[0];
                A_CLK: en_q[3] <= bus_wdata[0];
                A_RES: res_q   <= bus_wdata[2:0];
                A_THR: thr_q   <= bus_wdata[THR_W-1:0];
                A_MSK: msk_q   <= bus_wdata[5:4];
                A_LFT: left_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Sticky overrun: set by a push into a full FIFO, cleared by its read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovr_q <= 1'b0;
        else if (push && fifo_full) ovr_q <= 1'b1;
        else if (ovr_clr)           ovr_q <= 1'b0;
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_GLB: rd_mux[0]       = en_q[0];
            A_TXB: rd_mux[0]       = en_q[1];
            A_CHN: rd_mux[0]       = en_q[2];
            A_CLK: rd_mux[0]       = en_q[3];
            A_RES: rd_mux[2:0]     = res_q;
            A_THR: rd_mux[THR_W-1:0] = thr_q;
            A_MSK: rd_mux[5:4]     = msk_q;
            A_STS: rd_mux[5:4]     = {ovr_q, low_flag};
            A_OVC: rd_mux[0]       = ovr_q;
            default: ;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full) |=> ovr_q); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ovr_clr) |=> ovr_q); // R6
endmodule

// File: rtl/i2s_tx_serial.sv
`timescale 1ns/1ps
// Module: serialiser. On each bit strobe it emits one bit. A word-select
// change loads the next word, whose MSB leaves on the following strobe.
// Assumes each word-select half holds at least as many strobes as the
// resolution. Falling word select pops a pair; an empty FIFO yields zeros.
module i2s_tx_serial
    import i2s_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BITS_W = $clog2(DATA_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                bit_tick,
    input  logic                ws_in,
    input  logic [2:0]          res_code,
    input  logic                fifo_empty,
    input  logic [2*DATA_W-1:0] fifo_dout,
    output logic                pop,
    output logic                sd_out
);
    logic              ws_q, sd_q, edge_seen;
    logic [DATA_W-1:0] shreg, rhold, left_s, right_s;
    logic [BITS_W-1:0] bits_left, nbits, shamt;

    assign left_s    = fifo_dout[2*DATA_W-1 -: DATA_W];
    assign right_s   = fifo_dout[DATA_W-1:0];
    assign nbits     = (res_bits(res_code) <= DATA_W) ? BITS_W'(res_bits(res_code)) : '0;
    assign shamt     = BITS_W'(DATA_W) - nbits;
    assign edge_seen = (ws_in != ws_q);
    assign pop       = run && bit_tick && edge_seen && !ws_in && !fifo_empty;
    assign sd_out    = sd_q;

    // Left-justify a sample to the resolution; unsupported codes give zero.
    function automatic logic [DATA_W-1:0] align(input logic [DATA_W-1:0] s);
        return (nbits == '0) ? '0 : (s << shamt);
    endfunction

    // Bit output, shifting and word loading, idle while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ws_q      <= 1'b1;
            sd_q      <= 1'b0;
            shreg     <= '0;
            rhold     <= '0;
            bits_left <= '0;
        end else if (bit_tick) begin
            sd_q  <= (bits_left != '0) ? shreg[DATA_W-1] : 1'b0;
            shreg <= shreg << 1;
            ws_q  <= ws_in;
            if (bits_left != '0) bits_left <= bits_left - 1'b1;
            if (edge_seen) begin
                bits_left <= nbits;
                if (!ws_in) begin
                    shreg <= fifo_empty ? '0 : align(left_s);
                    rhold <= fifo_empty ? '0 : right_s;
                end else begin
                    shreg <= align(rhold);
                end
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sd_out); // R2
endmodule

// File: rtl/i2s_tx_chan.sv
`timescale 1ns/1ps
// Module: top of the stereo serial transmit channel. Joins the register
// file, the pair FIFO and the serialiser. Assumes bit strobe and word select
// are synchronous to clk.
module i2s_tx_chan
    import i2s_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              bit_tick,
    input  logic              ws_in,
    output logic              sd_out,
    output logic              irq_out
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = PTR_W + 1;
    localparam int PAIR_W = 2 * DATA_W;

    logic              run, push, flush, pop, fifo_full, fifo_empty;
    logic [2:0]        res_code;
    logic [PAIR_W-1:0] push_pair, fifo_dout;
    logic [CNT_W-1:0]  fifo_count;

    i2s_tx_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_count(fifo_count), .fifo_full(fifo_full), .run(run),
        .res_code(res_code), .push(push), .push_pair(push_pair),
        .flush(flush), .irq(irq_out)
    );

    i2s_tx_fifo #(.W(PAIR_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_pair), .pop(pop),
        .flush(flush), .dout(fifo_dout), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty)
    );

    i2s_tx_serial #(.DATA_W(DATA_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
        .ws_in(ws_in), .res_code(res_code), .fifo_empty(fifo_empty),
        .fifo_dout(fifo_dout), .pop(pop), .sd_out(sd_out)
    );
endmodule

// File: tb/i2s_tx_chan_bench.sv
`timescale 1ns/1ps
module i2s_tx_chan_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bit_tick = 1'b0, ws_in = 1'b1;
    logic sd_out, irq_out;

    always #2.5 clk = ~clk;

    i2s_tx_chan u_i2s_tx_chan (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bit_tick(bit_tick), .ws_in(ws_in), .sd_out(sd_out), .irq_out(irq_out)
    );

    int checks = 0, errors = 0;
    int hcnt = 0, ph = 0;
    int idle_ones = 0, pad_err = 0;
    int mon_bits = 16, bitcnt = 0;
    bit mon_on = 0, mon_busy = 0, collecting = 0, word_on = 0, cur_ch = 0, ws_last = 1;
    logic [31:0] word;
    logic [32:0] expq[$];
    logic [31:0] rv;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    // Driver: writes one pair and queues both expected words.
    task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
        reg_wr(4'd10, l);
        reg_wr(4'd11, r);
        expq.push_back({1'b0, l});
        expq.push_back({1'b1, r});
    endtask

    // Driver during a run: waits until the right word is done, before the next left.
    task automatic push_live(input logic [31:0] l, input logic [31:0] r);
        @(negedge clk);
        while (!(ws_in == 1'b1 && !mon_busy && hcnt < 24)) @(negedge clk);
        push_pair(l, r);
    endtask

    task automatic start_run();
        @(negedge clk);
        while (!(ws_in == 1'b1 && hcnt < 20)) @(negedge clk);
        reg_wr(4'd2, 32'd1);
        mon_on = 1'b1;
    endtask

    task automatic stop_run();
        mon_on = 1'b0;
        collecting = 1'b0;
        reg_wr(4'd2, 32'd0);
    endtask

    task automatic frames(input int n);
        repeat (n * 256) @(negedge clk);
    endtask

    // Bit strobe every 4 clocks, word select toggles every 32 strobes.
    initial begin
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            bit_tick = (ph == 0);
            if (ph == 0) begin
                hcnt++;
                if (hcnt == 32) begin
                    hcnt = 0;
                    ws_in = ~ws_in;
                end
            end
        end
    end

    // Monitor: rebuilds words from the line and compares against the queue.
    always @(posedge clk) begin
        if (bit_tick) begin
            bit ws_at, b;
            logic [31:0] msk;
            logic [32:0] e;
            ws_at = ws_in;
            #1;
            b = sd_out;
            msk = (mon_bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << mon_bits) - 32'd1);
            if (collecting && bitcnt < mon_bits) begin
                word = {word[30:0], b};
                bitcnt++;
                if (bitcnt == mon_bits) begin
                    mon_busy = 1'b0;
                    if (word_on) begin
                        if (expq.size() > 0) begin
                            e = expq.pop_front();
                            check(word == (e[31:0] & msk) && cur_ch == e[32], "R10",
                                  "word value/channel (R3 R4)", {cur_ch, word}, {e[32], e[31:0] & msk});
                        end else begin
                            check(word == 32'd0, "R9", "underflow word", word, 0);
                        end
                    end
                end
            end else if (mon_on && collecting && ws_at == ws_last && b) begin
                pad_err++;
            end
            if (ws_at != ws_last) begin
                collecting = 1'b1; bitcnt = 0; word = '0;
                cur_ch = ws_at; mon_busy = 1'b1; word_on = mon_on;
            end
            if (!mon_on && b) idle_ones++;
            ws_last = ws_at;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sd_out == 1'b0, "R1", "sd after reset", sd_out, 0);
        check(irq_out == 1'b0, "R1", "irq after reset", irq_out, 0);
        reg_rd(4'd4, rv); check(rv == 32'd2, "R1", "resolution reset", rv, 2);
        reg_rd(4'd5, rv); check(rv == 32'd7, "R1", "threshold reset", rv, 7);
        reg_rd(4'd6, rv); check(rv == 32'h30, "R1", "mask reset", rv, 'h30);
        reg_rd(4'd7, rv); check(rv == 32'h10, "R1", "status reset", rv, 'h10);

        // R7 masking of the low-level source
        reg_wr(4'd6, 32'h20); @(negedge clk);
        check(irq_out == 1'b1, "R7", "irq with low unmasked", irq_out, 1);
        reg_wr(4'd6, 32'h30); @(negedge clk);
        check(irq_out == 1'b0, "R7", "irq with all masked", irq_out, 0);

        // R5 threshold boundary: value 2 means level 3
        reg_wr(4'd5, 32'd2);
        push_pair(32'h1, 32'h2); push_pair(32'h3, 32'h4); push_pair(32'h5, 32'h6);
        reg_rd(4'd7, rv); check(rv == 32'h10, "R5", "status at level", rv, 'h10);
        push_pair(32'h7, 32'h8);
        reg_rd(4'd7, rv); check(rv == 32'h00, "R5", "status above level", rv, 0);

        // R2 partial enables: no output, nothing consumed
        reg_wr(4'd5, 32'd0);
        reg_wr(4'd0, 32'd1); reg_wr(4'd1, 32'd1); reg_wr(4'd3, 32'd1);
        idle_ones = 0;
        frames(2);
        reg_wr(4'd2, 32'd1); reg_wr(4'd0, 32'd0);
        frames(2);
        check(idle_ones == 0, "R2", "ones while disabled", idle_ones, 0);
        reg_rd(4'd7, rv); check(rv == 32'h00, "R2", "FIFO kept while disabled", rv, 0);
        reg_wr(4'd2, 32'd0); reg_wr(4'd0, 32'd1);

        // R8 flush keeps configuration
        reg_wr(4'd9, 32'd1);
        expq.delete();
        reg_rd(4'd7, rv); check(rv == 32'h10, "R8", "status after flush", rv, 'h10);
        reg_rd(4'd5, rv); check(rv == 32'd0, "R8", "threshold after flush", rv, 0);
        reg_rd(4'd4, rv); check(rv == 32'd2, "R8", "resolution after flush", rv, 2);
        reg_wr(4'd5, 32'd7);

        // R3 R4 R10 16-bit, then underflow frames (R9)
        mon_bits = 16;
        push_pair(32'hDEAD_A5C3, 32'h0BAD_3C5A);
        push_pair(32'h1234_8001, 32'h5678_7FFE);
        push_pair(32'hFFFF_0F0F, 32'h0000_F0F0);
        start_run(); frames(5);
        check(expq.size() == 0, "R10", "16-bit queue drained", expq.size(), 0);
        // R9 recovery after underflow
        push_live(32'h0000_C0DE, 32'h0000_BEEF);
        frames(2);
        check(expq.size() == 0, "R9", "pair after underflow sent", expq.size(), 0);
        stop_run();

        // R3 24-bit
        reg_wr(4'd4, 32'd4); mon_bits = 24;
        push_pair(32'hAB80_0001, 32'hCD12_3456);
        push_pair(32'h00FF_FFFF, 32'hFF00_0000);
        start_run(); frames(4);
        check(expq.size() == 0, "R3", "24-bit queue drained", expq.size(), 0);
        stop_run();

        // R3 32-bit: LSB shares its strobe with the next select change
        reg_wr(4'd4, 32'd5); mon_bits = 32;
        push_pair(32'h8000_0001, 32'h7FFF_FFFE);
        push_pair(32'hC3A5_5A3C, 32'h0123_4567);
        start_run(); frames(4);
        check(expq.size() == 0, "R3", "32-bit queue drained", expq.size(), 0);
        stop_run();

        // R3 unsupported code sends zeros
        reg_wr(4'd4, 32'd3); mon_bits = 16;
        reg_wr(4'd10, 32'hFFFF_FFFF); reg_wr(4'd11, 32'hFFFF_FFFF);
        start_run(); frames(3);
        stop_run();
        check(pad_err == 0, "R3", "no bits with unsupported code", pad_err, 0);

        // R6 overrun: 16 accepted, 17th dropped
        reg_wr(4'd9, 32'd1);
        reg_wr(4'd4, 32'd2);
        for (int i = 0; i < 16; i++) push_pair(32'h100 + i, 32'h200 + i);
        reg_rd(4'd7, rv); check(rv == 32'h00, "R6", "no overrun when full", rv, 0);
        reg_wr(4'd10, 32'h0000_9999); reg_wr(4'd11, 32'h0000_8888);
        reg_rd(4'd7, rv); check(rv == 32'h20, "R6", "overrun set", rv, 'h20);
        reg_rd(4'd7, rv); check(rv == 32'h20, "R6", "overrun sticky", rv, 'h20);
        reg_wr(4'd6, 32'h10); @(negedge clk);
        check(irq_out == 1'b1, "R7", "irq from overrun", irq_out, 1);
        reg_rd(4'd8, rv); check(rv == 32'd1, "R6", "clear read value", rv, 1);
        reg_rd(4'd7, rv); check(rv == 32'h00, "R6", "overrun cleared", rv, 0);
        @(negedge clk);
        check(irq_out == 1'b0, "R7", "irq after clear", irq_out, 0);
        reg_wr(4'd6, 32'h30);
        start_run(); frames(18);
        check(expq.size() == 0, "R6", "exactly 16 pairs sent", expq.size(), 0);
        stop_run();

        check(pad_err == 0, "R4", "zero padding after word", pad_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule